// File: doc/BRIEF.md
# Receive Frame Length Policer

This block sits in the receive byte path of an Ethernet MAC and checks the length of each frame against three policies. It flags frames that are longer than the giant-frame threshold that applies, and it truncates frames that run past a byte-count watchdog. It also decides from the length/type field whether the pad and frame check sequence may be stripped downstream. The bytes themselves pass through unchanged and in order. They leave on a valid/ready stream that carries frame start, frame end and a truncation marker.

The giant threshold depends on three plain control inputs: jumbo enable, 2K acceptance and a per-frame VLAN-tag flag. The watchdog limit depends on jumbo enable and on a watchdog-off input. Per-frame status is registered and shown for one cycle after the last input byte of a frame has been accepted. Back-pressure rules: while a byte is forwarded, `s_ready` equals `m_ready` in the same cycle, and the data, start and end are passed through combinationally. Bytes past the watchdog limit are consumed with `s_ready` high and never appear at the output. The control inputs and `rx_vlan` must be held stable from the first byte of a frame to its last.

The byte counter is CNT_W bits wide (15 by default) and saturates at its all-ones value instead of wrapping.

Top module: `rx_len_policer`

## Requirements
- R1: With jumbo off and 2K acceptance off, `st_giant` is 1 for a frame longer than 1518 bytes, or longer than 1522 bytes when `rx_vlan` is 1. It is 0 for a frame at or below that length.
- R2: With jumbo off and 2K acceptance on, frames of up to 2000 bytes give `st_giant`=0 and longer frames give 1, whatever `rx_vlan` is.
- R3: With jumbo on, `st_giant` is 1 only above 9018 bytes, or above 9022 bytes when `rx_vlan` is 1. The 2K acceptance input then has no effect.
- R4: With the watchdog on, the cut limit is 2048 bytes, or 10240 with jumbo on. In a longer frame, bytes 1 to the limit are forwarded. The byte at the limit carries `m_eof`=1 and `m_cut`=1. Later bytes are consumed but not forwarded, and `st_wd_cut`=1. A frame at or below the limit is forwarded whole with `m_cut`=0 and `st_wd_cut`=0.
- R5: With the watchdog off, frames of up to 16383 bytes are forwarded whole with `st_wd_cut`=0. A longer frame is cut at 16383 bytes in the manner of R4.
- R6: The length/type field is byte 13 (high) and byte 14 (low) of the frame, counting the first byte as 1. `st_strip` is 1 when the frame has at least 14 bytes and the field is below 1536 (0x0600). It is 0 when the field is 1536 or more, or the frame is shorter than 14 bytes.
- R7: `st_valid` is high for exactly the one cycle after the cycle in which a byte with `s_eof`=1 is accepted, and is low at all other times. `st_giant`, `st_wd_cut` and `st_strip` hold that frame's result.
- R8: Forwarded bytes leave in order and unchanged with their start marker. `s_ready` equals `m_ready` while a byte is forwarded and is 1 while a byte is dropped.
- R9: After reset, `st_valid` is 0 and the byte count starts from zero, so the first accepted byte is byte 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_jumbo | input | 1 | Jumbo frame enable |
| cfg_acc2k | input | 1 | Accept frames of up to 2000 bytes as normal |
| cfg_wd_off | input | 1 | Watchdog off (limit becomes 16383) |
| rx_vlan | input | 1 | Current frame carries a VLAN tag |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | First output byte of a frame |
| m_eof | output | 1 | Last output byte of a frame |
| m_cut | output | 1 | Frame truncated at this byte |
| st_valid | output | 1 | Status pulse after frame end |
| st_giant | output | 1 | Frame exceeded the giant threshold |
| st_wd_cut | output | 1 | Frame exceeded the watchdog limit |
| st_strip | output | 1 | Pad and FCS may be stripped |

## Verification
The hardest situations to reach are the exact threshold edges: a frame one byte under or over each giant threshold, and the watchdog cut at 10240 or 16383 bytes. At those points the cut byte must carry the end marker while the input keeps streaming. Directed frames of exactly those lengths are sent back to back under every relevant setting of jumbo, 2K acceptance, VLAN and watchdog-off. Random short frames with stalls on both sides cover the length field near 1536 and frames shorter than the field.

// File: rtl/rlp_pkg.sv
`timescale 1ns/1ps
package rlp_pkg;
  typedef struct packed {
    logic giant;
    logic wd_cut;
    logic strip;
  } rlp_status_t;
endpackage

// File: rtl/rlp_byte_counter.sv
`timescale 1ns/1ps
module rlp_byte_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] SAT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;

  // a start byte restarts the count; otherwise continue from the stored count
  always_comb begin
    base = sof ? '0 : cnt_q;
    idx  = (base == SAT_MAX) ? SAT_MAX : base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (beat) cnt_q <= eof ? '0 : idx;
  end

  // R5: inside a frame the count never falls back (saturation, no wrap)
  p_cnt_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && !eof) |=> (cnt_q >= $past(cnt_q)));

  // R9: a frame end returns the counter to its idle value
  p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eof) |=> (cnt_q == '0));
endmodule

// File: rtl/rlp_type_probe.sv
`timescale 1ns/1ps
module rlp_type_probe #(
  parameter int CNT_W  = 15,
  parameter int FLD_HI = 13,
  parameter int THRESH = 1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             eof,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             strip_ok
);
  localparam logic [CNT_W-1:0] IDX_HI = CNT_W'(FLD_HI);
  localparam logic [CNT_W-1:0] IDX_LO = CNT_W'(FLD_HI + 1);
  localparam logic [15:0]      LIM    = 16'(THRESH);

  logic [7:0]  hi_q, lo_q;
  logic        seen_q;
  logic [15:0] field;
  logic        have;

  // the low byte may arrive on the same beat as the frame end
  always_comb begin
    if (idx == IDX_LO) begin
      field = {hi_q, data};
      have  = 1'b1;
    end else begin
      field = {hi_q, lo_q};
      have  = seen_q;
    end
    strip_ok = have && (field < LIM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      seen_q <= 1'b0;
    end else if (beat) begin
      if (idx == IDX_HI) hi_q <= data;
      if (idx == IDX_LO) lo_q <= data;
      if (eof)                 seen_q <= 1'b0;
      else if (idx == IDX_LO)  seen_q <= 1'b1;
    end
  end

  // R6: no field survives into the next frame
  p_field_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && eof) |=> !seen_q);
endmodule

// File: rtl/rlp_limit_sel.sv
`timescale 1ns/1ps
module rlp_limit_sel #(
  parameter int CNT_W     = 15,
  parameter int STD_MAX   = 1518,
  parameter int TAG_EXTRA = 4,
  parameter int ACC_MAX   = 2000,
  parameter int JUMBO_MAX = 9018,
  parameter int WD_STD    = 2048,
  parameter int WD_JUMBO  = 10240,
  parameter int WD_OFF    = 16383
) (
  input  logic             jumbo,
  input  logic             acc2k,
  input  logic             wd_off,
  input  logic             vlan,
  output logic [CNT_W-1:0] giant_lim,
  output logic [CNT_W-1:0] cut_lim
);
  localparam logic [CNT_W-1:0] G_STD   = CNT_W'(STD_MAX);
  localparam logic [CNT_W-1:0] G_STD_T = CNT_W'(STD_MAX + TAG_EXTRA);
  localparam logic [CNT_W-1:0] G_ACC   = CNT_W'(ACC_MAX);
  localparam logic [CNT_W-1:0] G_JMB   = CNT_W'(JUMBO_MAX);
  localparam logic [CNT_W-1:0] G_JMB_T = CNT_W'(JUMBO_MAX + TAG_EXTRA);
  localparam logic [CNT_W-1:0] C_STD   = CNT_W'(WD_STD);
  localparam logic [CNT_W-1:0] C_JMB   = CNT_W'(WD_JUMBO);
  localparam logic [CNT_W-1:0] C_OFF   = CNT_W'(WD_OFF);

  // jumbo outranks 2K acceptance; the tag only widens standard and jumbo
  always_comb begin
    if (jumbo)      giant_lim = vlan ? G_JMB_T : G_JMB;
    else if (acc2k) giant_lim = G_ACC;
    else            giant_lim = vlan ? G_STD_T : G_STD;
    if (wd_off)     cut_lim = C_OFF;
    else            cut_lim = jumbo ? C_JMB : C_STD;
  end

  // R4: the cut limit always lies above the giant threshold
  always_comb begin
    p_cut_above_giant_r4: assert (cut_lim > giant_lim);
  end
endmodule

// File: rtl/rx_len_policer.sv
`timescale 1ns/1ps
module rx_len_policer #(
  parameter int CNT_W     = 15,
  parameter int STD_MAX   = 1518,
  parameter int TAG_EXTRA = 4,
  parameter int ACC_MAX   = 2000,
  parameter int JUMBO_MAX = 9018,
  parameter int WD_STD    = 2048,
  parameter int WD_JUMBO  = 10240,
  parameter int WD_OFF    = 16383,
  parameter int FLD_HI    = 13,
  parameter int THRESH    = 1536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_jumbo,
  input  logic       cfg_acc2k,
  input  logic       cfg_wd_off,
  input  logic       rx_vlan,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sof,
  input  logic       s_eof,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_sof,
  output logic       m_eof,
  output logic       m_cut,
  output logic       st_valid,
  output logic       st_giant,
  output logic       st_wd_cut,
  output logic       st_strip
);
  import rlp_pkg::*;

  logic [CNT_W-1:0] idx, giant_lim, cut_lim;
  logic             beat, over, at_lim, strip_ok;
  rlp_status_t      st_q;
  logic             st_valid_q;

  rlp_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof), .eof(s_eof), .idx(idx)
  );

  rlp_type_probe #(.CNT_W(CNT_W), .FLD_HI(FLD_HI), .THRESH(THRESH)) u_probe (
    .clk(clk), .rst_n(rst_n), .beat(beat), .eof(s_eof), .idx(idx),
    .data(s_data), .strip_ok(strip_ok)
  );

  rlp_limit_sel #(
    .CNT_W(CNT_W), .STD_MAX(STD_MAX), .TAG_EXTRA(TAG_EXTRA), .ACC_MAX(ACC_MAX),
    .JUMBO_MAX(JUMBO_MAX), .WD_STD(WD_STD), .WD_JUMBO(WD_JUMBO), .WD_OFF(WD_OFF)
  ) u_lim (
    .jumbo(cfg_jumbo), .acc2k(cfg_acc2k), .wd_off(cfg_wd_off), .vlan(rx_vlan),
    .giant_lim(giant_lim), .cut_lim(cut_lim)
  );

  // pass-through stream; bytes past the cut limit are swallowed
  always_comb begin
    over    = idx > cut_lim;
    at_lim  = idx == cut_lim;
    m_valid = s_valid && !over;
    s_ready = over ? 1'b1 : m_ready;
    m_data  = s_data;
    m_sof   = s_sof;
    m_eof   = s_eof || at_lim;
    m_cut   = at_lim && !s_eof;
    beat    = s_valid && s_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid_q <= 1'b0;
      st_q       <= '0;
    end else begin
      st_valid_q <= beat && s_eof;
      if (beat && s_eof) begin
        st_q.giant  <= idx > giant_lim;
        st_q.wd_cut <= idx > cut_lim;
        st_q.strip  <= strip_ok;
      end
    end
  end

  assign st_valid  = st_valid_q;
  assign st_giant  = st_q.giant;
  assign st_wd_cut = st_q.wd_cut;
  assign st_strip  = st_q.strip;

  // R7: one status pulse per accepted frame end, and none otherwise
  p_status_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && s_eof) |=> st_valid);
  p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && s_eof) |=> !st_valid);
  // R4: a watchdog cut frame is necessarily also giant
  p_cut_is_giant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_wd_cut) |-> st_giant);
  // R4: a truncation marker always closes the output frame
  p_cut_ends_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_cut) |-> m_eof);
  // R8: a dropped byte is always consumed
  p_drop_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !m_valid) |-> s_ready);
endmodule

// File: tb/test_rx_len_policer.sv
`timescale 1ns/1ps
module test_rx_len_policer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_jumbo, cfg_acc2k, cfg_wd_off, rx_vlan;
  logic s_valid, s_ready, s_sof, s_eof, m_valid, m_ready, m_sof, m_eof, m_cut;
  logic [7:0] s_data, m_data;
  logic st_valid, st_giant, st_wd_cut, st_strip;

  rx_len_policer i_rx_len_policer (
    .clk(clk), .rst_n(rst_n), .cfg_jumbo(cfg_jumbo), .cfg_acc2k(cfg_acc2k),
    .cfg_wd_off(cfg_wd_off), .rx_vlan(rx_vlan), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof), .m_cut(m_cut), .st_valid(st_valid),
    .st_giant(st_giant), .st_wd_cut(st_wd_cut), .st_strip(st_strip)
  );

  int n_tests = 0, n_fail = 0;
  int n_sent = 0, ofid = 0, sfid = 0, ocnt = 0, derr = 0, r8_err = 0;
  bit prev_eof = 0, done = 0;
  int  e_len[128], e_lt[128];
  bit  e_j[128], e_a[128], e_w[128], e_v[128];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int glim(bit j, bit a, bit v);
    if (j) return v ? 9022 : 9018;
    if (a) return 2000;
    return v ? 1522 : 1518;
  endfunction
  function automatic int clim(bit j, bit w);
    if (w) return 16383;
    return j ? 10240 : 2048;
  endfunction
  function automatic bit strip_exp(int len, int lt);
    return (len >= 14) && (lt < 1536);
  endfunction
  function automatic logic [7:0] bdat(int fid, int i, int lt);
    if (i == 13) return 8'((lt >> 8) & 255);
    if (i == 14) return 8'(lt & 255);
    return 8'((i * 7 + fid * 3) & 255);
  endfunction
  function automatic string gtag(int fid);
    if (e_j[fid]) return "R3";
    if (e_a[fid]) return "R2";
    return "R1";
  endfunction
  function automatic string ctag(int fid);
    return e_w[fid] ? "R5" : "R4";
  endfunction

  task automatic send(int len, int lt, bit j, bit a, bit w, bit v, bit bp);
    int fid;
    fid = n_sent;
    e_len[fid] = len; e_lt[fid] = lt; e_j[fid] = j; e_a[fid] = a; e_w[fid] = w; e_v[fid] = v;
    n_sent++;
    @(negedge clk);
    cfg_jumbo = j; cfg_acc2k = a; cfg_wd_off = w; rx_vlan = v;
    for (int i = 1; i <= len; i++) begin
      if (bp) begin
        while ($urandom % 4 == 0) begin
          s_valid = 1'b0; m_ready = 1'($urandom % 2);
          @(negedge clk);
        end
      end
      s_valid = 1'b1; s_data = bdat(fid, i, lt); s_sof = (i == 1); s_eof = (i == len);
      forever begin
        m_ready = bp ? ($urandom % 4 != 0) : 1'b1;
        #1;
        if (s_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; m_ready = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // monitor, sampled away from the rising edge
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && !done) begin
        if (s_valid && m_valid && (s_ready != m_ready || m_data != s_data)) r8_err++;
        if (s_valid && !m_valid && !s_ready) r8_err++;
        if (m_valid && m_ready) begin
          if (m_sof) begin ocnt = 0; derr = 0; end
          ocnt++;
          if (m_data != bdat(ofid, ocnt, e_lt[ofid])) derr++;
          if (m_eof) begin
            chk(ocnt == ((e_len[ofid] < clim(e_j[ofid], e_w[ofid])) ? e_len[ofid]
                         : clim(e_j[ofid], e_w[ofid])), ctag(ofid), "forwarded bytes",
                ocnt, e_len[ofid]);
            chk(m_cut == (e_len[ofid] > clim(e_j[ofid], e_w[ofid])), ctag(ofid),
                "cut marker", int'(m_cut), int'(e_len[ofid] > clim(e_j[ofid], e_w[ofid])));
            chk(derr == 0, "R8", "byte content errors", derr, 0);
            ofid++;
          end
        end
        if (st_valid || prev_eof) begin
          chk(st_valid == prev_eof, "R7", "status pulse timing", int'(st_valid), int'(prev_eof));
          if (st_valid) begin
            chk(st_giant == (e_len[sfid] > glim(e_j[sfid], e_a[sfid], e_v[sfid])), gtag(sfid),
                "giant flag", int'(st_giant), int'(e_len[sfid] > glim(e_j[sfid], e_a[sfid], e_v[sfid])));
            chk(st_wd_cut == (e_len[sfid] > clim(e_j[sfid], e_w[sfid])), ctag(sfid),
                "watchdog cut flag", int'(st_wd_cut), int'(e_len[sfid] > clim(e_j[sfid], e_w[sfid])));
            chk(st_strip == strip_exp(e_len[sfid], e_lt[sfid]), "R6", "strip flag",
                int'(st_strip), int'(strip_exp(e_len[sfid], e_lt[sfid])));
            sfid++;
          end
        end
        prev_eof = s_valid && s_ready && s_eof;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; cfg_jumbo = 0; cfg_acc2k = 0; cfg_wd_off = 0; rx_vlan = 0;
    s_valid = 0; s_sof = 0; s_eof = 0; s_data = '0; m_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(st_valid == 1'b0, "R9", "status valid after reset", int'(st_valid), 0);
    chk(m_valid == 1'b0, "R9", "output valid after reset", int'(m_valid), 0);
    // R9: first frame after reset: 1-byte frame counted as byte 1, no strip
    send(1, 0, 0, 0, 0, 0, 0);
    // R6: field edges and too-short frames
    send(14, 1535, 0, 0, 0, 0, 0);
    send(14, 1536, 0, 0, 0, 0, 0);
    send(13, 100, 0, 0, 0, 0, 0);
    // R1: standard and tagged thresholds
    send(1518, 46, 0, 0, 0, 0, 0);
    send(1519, 46, 0, 0, 0, 0, 0);
    send(1522, 2048, 0, 0, 0, 1, 0);
    send(1523, 2048, 0, 0, 0, 1, 0);
    // R2: 2K acceptance, tag adds nothing
    send(2000, 9, 0, 1, 0, 0, 0);
    send(2001, 9, 0, 1, 0, 0, 0);
    send(2001, 9, 0, 1, 0, 1, 0);
    // R3: jumbo thresholds, 2K acceptance ignored
    send(9018, 1600, 1, 0, 0, 0, 0);
    send(9019, 1600, 1, 1, 0, 0, 0);
    send(9022, 1600, 1, 1, 0, 1, 0);
    send(9023, 1600, 1, 0, 0, 1, 0);
    // R4: watchdog cut limits
    send(2048, 5, 0, 0, 0, 0, 0);
    send(2049, 5, 0, 0, 0, 0, 0);
    send(10240, 5, 1, 0, 0, 0, 0);
    send(10241, 5, 1, 0, 0, 0, 0);
    // R5: watchdog off
    send(16383, 5, 1, 0, 1, 0, 0);
    send(16384, 5, 0, 0, 1, 0, 0);
    // R8 and R6: random short frames under back-pressure
    for (int k = 0; k < 60; k++) begin
      int ln, lt;
      ln = 1 + int'($urandom % 60);
      case ($urandom % 4)
        0: lt = 1535;
        1: lt = 1536;
        2: lt = int'($urandom % 1536);
        default: lt = int'($urandom % 65536);
      endcase
      send(ln, lt, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    end
    repeat (5) @(negedge clk);
    done = 1;
    chk(ofid == n_sent, "R8", "output frames seen", ofid, n_sent);
    chk(sfid == n_sent, "R7", "status pulses seen", sfid, n_sent);
    chk(r8_err == 0, "R8", "handshake rule violations", r8_err, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule